// File: doc/BRIEF.md
# Byte-Wide Asynchronous Configuration Receiver

This block is the receiving end of a byte-wide configuration port that a host processor drives without a shared clock. The host raises a configuration-request line to leave the reset stage; the block then stops pulling its open-drain status line low. From that point the host selects the block, puts a byte on the data bus and pulses an active-low write strobe. The block takes the byte on the strobe's rising edge and hands it to an internal consumer that needs a fixed number of internal clock cycles per byte. A ready/busy output is low for that whole interval.

All host-side lines are brought into the internal clock domain through two-flop synchronizers, and strobe edges are found there. The data and select lines travel down a pipeline of matching depth, so the byte taken is the one that was on the bus while the strobe was last seen low. A host that does not wire up ready/busy can pull a read-status strobe low instead. The block then drives ready/busy on data bit 7 and leaves the other seven bits undriven. A strobe that arrives while a byte is still being consumed is dropped and sets a sticky overrun flag. A counter gives the number of bytes taken since the last reset stage.

Top module: `cfg_byte_port`

## Requirements
- R1: While the synchronized configuration request is low, or rst_n is low, the block is in the reset stage. In that stage status_low_o is 1 (status pulled low), ready_o is 0, byte_cnt_o is 0 and overrun_o is 0.
- R2: status_low_o goes to 0 on the third rising clock edge after cfg_req_i rises. It goes back to 1 on the third edge after cfg_req_i falls.
- R3: A write strobe rise is ignored unless the block is selected when the strobe was last sampled low. Selected means sel_n_i is 0, or sel_i is 1, or both. An ignored write leaves byte_o, byte_cnt_o and ready_o unchanged.
- R4: An accepted byte appears on byte_o on the third rising edge after wr_n_i rises. byte_vld_o is 1 for exactly that one cycle. The value is the one on data_i while wr_n_i was low, so a change of data_i at the moment of the rise is not taken.
- R5: After an accepted write, ready_o is 0 from the third edge after the strobe rise for exactly PROC_CYCLES cycles (default 8). It is 1 again from edge 3+PROC_CYCLES.
- R6: In the configuration stage, ready_o is 1 whenever no byte is being consumed.
- R7: Two edges after rs_n_i falls, data_oe_o is 8'h80 and data_o is {ready_o, 7'b0}. Two edges after rs_n_i rises, data_oe_o and data_o are both 0.
- R8: A selected write strobe rise while ready_o is 0 in the configuration stage is ignored. byte_o, byte_cnt_o and the end of the busy interval stay unchanged, and no byte_vld_o pulse occurs. overrun_o becomes 1 on the third edge after that rise and stays 1 until the reset stage.
- R9: byte_cnt_o rises by one in the cycle each accepted byte appears on byte_o, wrapping at 2^CNT_W. It returns to 0 in the reset stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_req_i | input | 1 | Configuration request from host; low = reset stage |
| sel_n_i | input | 1 | Active-low select |
| sel_i | input | 1 | Active-high select |
| wr_n_i | input | 1 | Active-low write strobe; byte taken on its rise |
| rs_n_i | input | 1 | Active-low read-status strobe |
| data_i | input | 8 | Data bus as seen at the pins |
| data_o | output | 8 | Value driven onto the data bus |
| data_oe_o | output | 8 | Per-bit output enable for the data bus |
| status_low_o | output | 1 | 1 = open-drain status line pulled low |
| ready_o | output | 1 | Ready (1) / busy (0) |
| byte_o | output | 8 | Last accepted byte, to the consumer |
| byte_vld_o | output | 1 | One-cycle pulse with each new byte_o |
| byte_cnt_o | output | CNT_W | Bytes accepted since the last reset stage |
| overrun_o | output | 1 | Sticky: a write came while busy |

## Verification
Every host-side input goes through two flops. A registered result therefore lands on the third rising edge after the input changes: the stage change, the captured byte, the counter step, the start of busy and the overrun flag. The read-status enables are combinational from the second flop, so they land on the second edge. The bench changes inputs on falling edges and counts posedges from that change to the exact edge where a result is due. It samples one time unit after that edge. Where a requirement says a result has not yet appeared, it also samples one edge earlier. For the busy interval it samples the last busy cycle and the first ready cycle.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic { ST_RESET = 1'b0, ST_CONFIG = 1'b1 } stage_e;

  // select is met by either polarity of the two select lines
  function automatic logic f_sel_ok(input logic sel_n, input logic sel);
    return (~sel_n) | sel;
  endfunction

  // word placed on the bus during a read-status strobe
  function automatic logic [7:0] f_status_word(input logic rdy);
    return {rdy, 7'b0};
  endfunction

  // output enables during a read-status strobe: only bit 7
  function automatic logic [7:0] f_status_oe(input logic rs_active);
    return rs_active ? 8'h80 : 8'h00;
  endfunction

endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cfgp_wr_capture.sv
module cfgp_wr_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n_s,
  input  logic          sel_s,
  input  logic [DW-1:0] data_s,
  output logic          wr_rise,
  output logic          sel_ok,
  output logic [DW-1:0] data_q
);
  // one more stage: holds the sample taken while the strobe was still low
  logic          wr_prev_q;
  logic          sel_prev_q;
  logic [DW-1:0] data_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q   <= 1'b1;
      sel_prev_q  <= 1'b0;
      data_prev_q <= '0;
    end else begin
      wr_prev_q   <= wr_n_s;
      sel_prev_q  <= sel_s;
      data_prev_q <= data_s;
    end
  end

  assign wr_rise = wr_n_s & ~wr_prev_q;
  assign sel_ok  = sel_prev_q;
  assign data_q  = data_prev_q;
endmodule

// File: rtl/cfgp_engine.sv
module cfgp_engine
  import cfgp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CNT_W       = 16,
  parameter int PROC_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_s,
  input  logic             wr_rise,
  input  logic             sel_ok,
  input  logic [DW-1:0]    data_q,
  output logic             in_cfg,
  output logic             ready,
  output logic             accept_ev,
  output logic             overrun_ev,
  output logic [DW-1:0]    byte_o,
  output logic             byte_vld_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             overrun_o
);
  localparam int BW = $clog2(PROC_CYCLES + 1);
  localparam logic [BW-1:0] LOAD = BW'(PROC_CYCLES);

  stage_e          stage_q;
  logic [BW-1:0]   busy_q;
  logic [DW-1:0]   byte_q;
  logic            vld_q;
  logic [CNT_W-1:0] cnt_q;
  logic            ovr_q;
  logic            wr_qual;

  assign in_cfg     = (stage_q == ST_CONFIG);
  assign ready      = in_cfg && (busy_q == '0);
  assign wr_qual    = wr_rise && sel_ok && in_cfg;
  assign accept_ev  = wr_qual && ready;
  assign overrun_ev = wr_qual && !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= ST_RESET;
    else        stage_q <= cfg_s ? ST_CONFIG : ST_RESET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else if (!in_cfg) begin
      busy_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= accept_ev;
      if (accept_ev) begin
        busy_q <= LOAD;
        cnt_q  <= cnt_q + 1'b1;
        byte_q <= data_q;
      end else if (busy_q != '0) begin
        busy_q <= busy_q - 1'b1;
      end
      if (overrun_ev) ovr_q <= 1'b1;
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
  assign byte_cnt_o = cnt_q;
  assign overrun_o  = ovr_q;
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
  import cfgp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PROC_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req_i,
  input  logic             sel_n_i,
  input  logic             sel_i,
  input  logic             wr_n_i,
  input  logic             rs_n_i,
  input  logic [7:0]       data_i,
  output logic [7:0]       data_o,
  output logic [7:0]       data_oe_o,
  output logic             status_low_o,
  output logic             ready_o,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             overrun_o
);
  localparam int DW  = 8;
  localparam int WPW = DW + 2;  // strobe, select, data travel together

  logic           cfg_s;
  logic           rs_n_s;
  logic [WPW-1:0] wpath_s;
  logic           wr_rise_w;
  logic           sel_ok_w;
  logic [DW-1:0]  data_q_w;
  logic           in_cfg_w;
  logic           ready_w;
  logic           accept_w;
  logic           overrun_ev_w;

  cfgp_sync #(.W(1), .RST_VAL(1'b0)) u_sync_cfg (
    .clk(clk), .rst_n(rst_n), .d_i(cfg_req_i), .q_o(cfg_s)
  );

  cfgp_sync #(.W(1), .RST_VAL(1'b1)) u_sync_rs (
    .clk(clk), .rst_n(rst_n), .d_i(rs_n_i), .q_o(rs_n_s)
  );

  cfgp_sync #(.W(WPW), .RST_VAL({1'b1, 1'b0, {DW{1'b0}}})) u_sync_wr (
    .clk(clk), .rst_n(rst_n),
    .d_i({wr_n_i, f_sel_ok(sel_n_i, sel_i), data_i}),
    .q_o(wpath_s)
  );

  cfgp_wr_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .wr_n_s(wpath_s[WPW-1]), .sel_s(wpath_s[WPW-2]), .data_s(wpath_s[DW-1:0]),
    .wr_rise(wr_rise_w), .sel_ok(sel_ok_w), .data_q(data_q_w)
  );

  cfgp_engine #(.DW(DW), .CNT_W(CNT_W), .PROC_CYCLES(PROC_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .cfg_s(cfg_s),
    .wr_rise(wr_rise_w), .sel_ok(sel_ok_w), .data_q(data_q_w),
    .in_cfg(in_cfg_w), .ready(ready_w),
    .accept_ev(accept_w), .overrun_ev(overrun_ev_w),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o),
    .byte_cnt_o(byte_cnt_o), .overrun_o(overrun_o)
  );

  assign status_low_o = ~in_cfg_w;
  assign ready_o      = ready_w;
  assign data_oe_o    = f_status_oe(~rs_n_s);
  assign data_o       = rs_n_s ? 8'h00 : f_status_word(ready_w);
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_s,
  input logic             in_cfg,
  input logic             wr_rise,
  input logic             sel_ok,
  input logic             accept_ev,
  input logic             overrun_ev,
  input logic             status_low_o,
  input logic             ready_o,
  input logic             byte_vld_o,
  input logic [7:0]       byte_o,
  input logic [CNT_W-1:0] byte_cnt_o,
  input logic             overrun_o,
  input logic [7:0]       data_o,
  input logic [7:0]       data_oe_o
);
  AST_RESET_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_s |=> (status_low_o && !ready_o)) else $error("AST_RESET_STAGE"); // R1

  AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_s |=> !status_low_o) else $error("AST_STAGE_FOLLOWS"); // R2

  AST_UNSEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !sel_ok && in_cfg) |=> ($stable(byte_cnt_o) && !byte_vld_o)) else $error("AST_UNSEL_IGNORED"); // R3

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o) else $error("AST_VLD_SINGLE"); // R4

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && in_cfg) |=> (!ready_o && byte_vld_o)) else $error("AST_ACCEPT_BUSY"); // R5

  AST_RS_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o != 8'h00) |-> (data_oe_o == 8'h80 && data_o[6:0] == 7'd0 && data_o[7] == ready_o)) else $error("AST_RS_MUX"); // R7

  AST_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> (overrun_o && $stable(byte_cnt_o) && $stable(byte_o))) else $error("AST_BUSY_WRITE"); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && in_cfg) |=> overrun_o) else $error("AST_OVR_STICKY"); // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (byte_cnt_o == $past(byte_cnt_o) + 1'b1)) else $error("AST_CNT_STEP"); // R9

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cfg |=> (byte_cnt_o == '0 && !overrun_o)) else $error("AST_CNT_CLEAR"); // R9
endmodule

bind cfg_byte_port cfgp_chk #(.CNT_W(CNT_W)) u_cfgp_chk (
  .clk(clk), .rst_n(rst_n), .cfg_s(cfg_s), .in_cfg(in_cfg_w),
  .wr_rise(wr_rise_w), .sel_ok(sel_ok_w),
  .accept_ev(accept_w), .overrun_ev(overrun_ev_w),
  .status_low_o(status_low_o), .ready_o(ready_o),
  .byte_vld_o(byte_vld_o), .byte_o(byte_o), .byte_cnt_o(byte_cnt_o),
  .overrun_o(overrun_o), .data_o(data_o), .data_oe_o(data_oe_o)
);

// File: tb/cfg_byte_port_tb_top.sv
module cfg_byte_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int PROC       = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_req = 1'b0, sel_n = 1'b0, sel = 1'b0, wr_n = 1'b1, rs_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, doe, byte_v;
  logic status_low, ready, vld, ovr;
  logic [CNT_W-1:0] cnt;

  int n_tests = 0;
  int n_fail  = 0;
  int vld_seen = 0;
  logic [CNT_W-1:0] exp_cnt = '0;
  logic [7:0] exp_byte = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_byte_port #(.CNT_W(CNT_W), .PROC_CYCLES(PROC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_req_i(cfg_req), .sel_n_i(sel_n), .sel_i(sel),
    .wr_n_i(wr_n), .rs_n_i(rs_n), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .status_low_o(status_low), .ready_o(ready), .byte_o(byte_v), .byte_vld_o(vld),
    .byte_cnt_o(cnt), .overrun_o(ovr)
  );

  always @(negedge clk) if (vld) vld_seen++;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // strobe low for two cycles; data changes to ~d at the rise (R4 capture point)
  task automatic wr_pulse(input logic [7:0] d);
    @(negedge clk);
    din  = d;
    wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    din  = ~d;
  endtask

  task automatic t_reset();
    chk("R1", "status in rst", 32'(status_low), 1);
    chk("R1", "ready in rst", 32'(ready), 0);
    @(negedge clk); rst_n = 1'b1;
    tick(5);
    chk("R1", "status cfg low", 32'(status_low), 1);
    chk("R1", "ready cfg low", 32'(ready), 0);
    chk("R1", "count", 32'(cnt), 0);
    chk("R1", "overrun", 32'(ovr), 0);
    chk("R7", "oe idle", 32'(doe), 0);
  endtask

  task automatic t_enter();
    @(negedge clk); cfg_req = 1'b1;
    tick(2);
    chk("R2", "status before 3rd edge", 32'(status_low), 1);
    tick(1);
    chk("R2", "status released", 32'(status_low), 0);
    chk("R6", "ready idle", 32'(ready), 1);
  endtask

  task automatic t_write(input logic [7:0] d, input logic sn, input logic s, input bit accept, input string req);
    int v0;
    v0 = vld_seen;
    sel_n = sn; sel = s;
    wr_pulse(d);
    tick(2);
    chk(req, "no early count", 32'(cnt), 32'(exp_cnt));
    tick(1);
    if (accept) begin
      exp_cnt++;
      exp_byte = d;
    end
    chk(req, "byte", 32'(byte_v), 32'(exp_byte));
    chk("R9", "count", 32'(cnt), 32'(exp_cnt));
    chk("R4", "vld now", 32'(vld), 32'(accept));
    if (accept) begin
      tick(PROC - 1);
      chk("R5", "busy last cycle", 32'(ready), 0);
      tick(1);
      chk("R5", "ready again", 32'(ready), 1);
      chk("R4", "one pulse", 32'(vld_seen - v0), 1);
    end else begin
      chk("R3", "ready kept", 32'(ready), 1);
      tick(2);
      chk("R3", "no pulse", 32'(vld_seen - v0), 0);
    end
    sel_n = 1'b0; sel = 1'b0;
  endtask

  task automatic t_overrun();
    int v0;
    wr_pulse(8'h3C);
    tick(3);               // edge 3 after first rise: busy starts
    exp_cnt++; exp_byte = 8'h3C;
    v0 = vld_seen;
    chk("R8", "busy", 32'(ready), 0);
    chk("R8", "ovr clear", 32'(ovr), 0);
    wr_pulse(8'hC3);       // rise before edge 6
    tick(3);               // edge 8
    chk("R8", "overrun set", 32'(ovr), 1);
    chk("R8", "count kept", 32'(cnt), 32'(exp_cnt));
    chk("R8", "byte kept", 32'(byte_v), 8'h3C);
    tick(2);               // edge 10 (3+PROC-1)
    chk("R8", "busy end unchanged", 32'(ready), 0);
    tick(1);
    chk("R8", "ready at 3+PROC", 32'(ready), 1);
    chk("R8", "no pulse", 32'(vld_seen - v0), 1);
    t_write(8'h77, 1'b0, 1'b0, 1'b1, "R4");
    chk("R8", "sticky", 32'(ovr), 1);
  endtask

  task automatic t_rs();
    @(negedge clk); rs_n = 1'b0;
    tick(1);
    chk("R7", "oe not yet", 32'(doe), 0);
    tick(1);
    chk("R7", "oe ready", 32'(doe), 8'h80);
    chk("R7", "data ready", 32'(dout), 8'h80);
    @(negedge clk); rs_n = 1'b1;
    tick(2);
    chk("R7", "oe released", 32'(doe), 0);
    chk("R7", "data released", 32'(dout), 0);
    wr_pulse(8'h5A);
    tick(3);
    exp_cnt++; exp_byte = 8'h5A;
    @(negedge clk); rs_n = 1'b0;
    tick(2);
    chk("R7", "oe busy", 32'(doe), 8'h80);
    chk("R7", "data busy", 32'(dout), 0);
    @(negedge clk); rs_n = 1'b1;
    tick(PROC);
    chk("R6", "ready after rs", 32'(ready), 1);
  endtask

  task automatic t_drop();
    wr_pulse(8'h99);
    tick(3);
    @(negedge clk); cfg_req = 1'b0;
    tick(2);
    chk("R2", "status before fall edge", 32'(status_low), 0);
    tick(1);
    chk("R2", "status pulled", 32'(status_low), 1);
    tick(1);
    chk("R1", "ready reset", 32'(ready), 0);
    chk("R9", "count cleared", 32'(cnt), 0);
    chk("R1", "overrun cleared", 32'(ovr), 0);
    exp_cnt = '0;
    @(negedge clk); cfg_req = 1'b1;
    tick(3);
    chk("R6", "ready after reentry", 32'(ready), 1);
    chk("R9", "count stays 0", 32'(cnt), 0);
    wr_pulse(8'h01);  // in config stage, accepted
    tick(3);
    chk("R9", "count 1", 32'(cnt), 1);
  endtask

  initial begin
    tick(2);
    t_reset();
    t_enter();
    t_write(8'hA5, 1'b0, 1'b0, 1'b1, "R4");
    t_write(8'h12, 1'b1, 1'b1, 1'b1, "R3");
    t_write(8'hE7, 1'b1, 1'b0, 1'b0, "R3");
    t_write(8'h4B, 1'b0, 1'b1, 1'b1, "R3");
    t_overrun();
    t_rs();
    t_drop();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule